// File: doc/BRIEF.md
# ADC Channel Mean and Variance Monitor

This block watches a stream of ADC output codes that arrive in parallel for several channels and works out simple statistics for them. Over a window whose length is a power of two, it adds up the samples of one channel and the squares of those samples. When the window closes it reports the mean and the variance of that channel in a result register that belongs to that channel. A configuration input picks the window length as an exponent. Either one fixed channel is measured, or the block steps through every channel in turn, in which case a full measurement takes as many windows as there are channels.

A single clock cycle of `stat_done` marks the end of a whole measurement: the one window in single-channel mode, or the last channel's window in sweep mode. While the block stays enabled it then starts the next measurement at once. Clearing the enable freezes all result registers and empties the accumulators. A change to the window exponent, the channel select or the sweep mode while enabled throws the current window away and starts again from the first channel.

Top module: `adc_stat_monitor`

## Requirements
- R1: After reset every mean and variance result register reads zero and `stat_done` is low.
- R2: With `cfg_cycle` = c, a window closes on the 2^(c+1)-th accepted sample (c from 0 to 15, so windows run from 2 to 65536 samples). Its results are visible, and `stat_done` is high, in the cycle after the clock edge that follows the edge that accepted that last sample.
- R3: Channel n's 14-bit two's complement sample sits at `smp_data[14n+13:14n]`. The mean written to `res_mean[14n+13:14n]` is the window's sample sum arithmetically shifted right by c+1.
- R4: The variance written to `res_var[28n+27:28n]` is (sum of squares shifted right by c+1) minus the square of the reported mean, forced to zero when that difference is negative.
- R5: With `cfg_sweep` = 0, only the channel named by `cfg_chan` is measured, and the result registers of every other channel keep their values.
- R6: With `cfg_sweep` = 1, channels 0, 1, 2, 3 are measured in consecutive full windows in ascending order. Each channel's registers update when its own window closes, and `stat_done` rises only after channel 3.
- R7: After a completed measurement the block starts the next one at once while `cfg_enable` stays high. In sweep mode it starts again at channel 0.
- R8: While `cfg_enable` is low, no result register changes, `stat_done` stays low and the accumulators are cleared, so a window begun after re-enabling counts only the samples after re-enabling.
- R9: A change of `cfg_cycle`, `cfg_chan` or `cfg_sweep` while enabled drops the sample of that cycle, discards the running window and restarts at channel 0 with cleared accumulators. This takes priority over a window that would close in the same cycle: no result is written and `stat_done` stays low.
- R10: Cycles with `smp_valid` low neither count toward the window nor enter the sums, whatever `smp_data` holds.
- R11: `stat_done` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Enables measurement; low clears the accumulators and freezes the results |
| cfg_cycle | input | 4 | Window exponent c; the window is 2^(c+1) samples |
| cfg_chan | input | 2 | Channel measured when sweep is off |
| cfg_sweep | input | 1 | 1 = measure every channel in ascending order |
| smp_valid | input | 1 | The sample words of this cycle are valid |
| smp_data | input | 56 | Four 14-bit two's complement samples, channel n at bits 14n+13:14n |
| res_mean | output | 56 | Per-channel mean results, channel n at bits 14n+13:14n |
| res_var | output | 112 | Per-channel variance results, channel n at bits 28n+27:28n |
| stat_done | output | 1 | One-cycle pulse when a measurement completes |

## Verification
A configuration change and the final sample of a window can fall in the same cycle. In that case the abort wins and the window's result must not be written. The bench sets up such a collision: in a four-sample window it drives the fourth valid sample in the same cycle as a new `cfg_cycle` value. Two cycles later it checks that channel 3's mean and variance still hold their earlier values and that no done pulse has appeared. It then runs a full window under the new exponent to confirm that the count restarted from zero. A second case aborts a sweep in the middle of channel 2 and expects the next result to land on channel 0.

// File: rtl/adc_stat_pkg.sv
// Shared definitions for the ADC statistics monitor.
// Assumes: only the sweep-mode encoding needs to be shared.
package adc_stat_pkg;
    typedef enum logic {
        SWEEP_OFF = 1'b0,
        SWEEP_ON  = 1'b1
    } sweep_e;
endpackage

// File: rtl/stat_sequencer.sv
// Window and channel sequencer.
// Counts accepted samples, finds the end of each window, steps the
// channel in sweep mode and raises flush when measuring must restart.
// Assumes: NUM_CH is a power of two and SEL_W = log2(NUM_CH).
module stat_sequencer
    import adc_stat_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CYC_W  = 4,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             valid,
    input  logic [CYC_W-1:0] cfg_cycle,
    input  logic [SEL_W-1:0] cfg_chan,
    input  logic             cfg_sweep,
    output logic [SEL_W-1:0] cur_ch,
    output logic             take,
    output logic             win_end,
    output logic             last_win,
    output logic             flush
);
    logic [CYC_W-1:0] cyc_q;
    logic [SEL_W-1:0] chan_q;
    logic             sweep_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] idx_q;
    logic [CNT_W-1:0] win_last;
    logic             cfg_chg;
    sweep_e           mode;

    assign mode     = sweep_e'(cfg_sweep);
    assign cfg_chg  = (cfg_cycle != cyc_q) || (cfg_chan != chan_q) || (cfg_sweep != sweep_q);
    assign flush    = !enable || cfg_chg;
    assign take     = enable && !cfg_chg && valid;
    assign win_last = (CNT_W'(2) << cfg_cycle) - CNT_W'(1);
    assign win_end  = take && (cnt_q == win_last);
    assign cur_ch   = (mode == SWEEP_ON) ? idx_q : cfg_chan;
    assign last_win = (mode == SWEEP_OFF) || (idx_q == SEL_W'(NUM_CH - 1));

    // Keep the last seen configuration to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            chan_q  <= '0;
            sweep_q <= 1'b0;
        end else begin
            cyc_q   <= cfg_cycle;
            chan_q  <= cfg_chan;
            sweep_q <= cfg_sweep;
        end
    end

    // Advance the sample count and the sweep channel index.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (win_end) begin
            cnt_q <= '0;
            if (mode == SWEEP_ON && idx_q != SEL_W'(NUM_CH - 1))
                idx_q <= idx_q + SEL_W'(1);
            else
                idx_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/stat_accum.sv
// Sum and sum-of-squares accumulator with a snapshot stage.
// When a window closes, the totals including the last sample are
// copied into the snapshot and the running sums restart from zero, so
// a sample in the next cycle is not lost.
// Assumes: SUM_W and SQ_W are wide enough for the largest window.
module stat_accum #(
    parameter int SAMPLE_W = 14,
    parameter int CYC_W    = 4,
    parameter int SEL_W    = 2,
    parameter int SUM_W    = 30,
    parameter int SQ_W     = 43
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       take,
    input  logic                       win_end,
    input  logic                       last_win,
    input  logic [SEL_W-1:0]           ch,
    input  logic [CYC_W-1:0]           cycle,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       snap_vld,
    output logic                       snap_last,
    output logic [SEL_W-1:0]           snap_ch,
    output logic [CYC_W-1:0]           snap_cyc,
    output logic signed [SUM_W-1:0]    snap_sum,
    output logic [SQ_W-1:0]            snap_sq
);
    logic signed [2*SAMPLE_W-1:0] prod;
    logic signed [SUM_W-1:0]      sum_q;
    logic signed [SUM_W-1:0]      sum_nx;
    logic [SQ_W-1:0]              sq_q;
    logic [SQ_W-1:0]              sq_nx;

    assign prod   = sample * sample;
    assign sum_nx = sum_q + SUM_W'(sample);
    assign sq_nx  = sq_q + SQ_W'($unsigned(prod));

    // Running totals of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || win_end) begin
            sum_q <= '0;
            sq_q  <= '0;
        end else if (take) begin
            sum_q <= sum_nx;
            sq_q  <= sq_nx;
        end
    end

    // Snapshot of a completed window for the finishing stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_vld  <= 1'b0;
            snap_last <= 1'b0;
            snap_ch   <= '0;
            snap_cyc  <= '0;
            snap_sum  <= '0;
            snap_sq   <= '0;
        end else begin
            snap_vld <= win_end;
            if (win_end) begin
                snap_last <= last_win;
                snap_ch   <= ch;
                snap_cyc  <= cycle;
                snap_sum  <= sum_nx;
                snap_sq   <= sq_nx;
            end
        end
    end
endmodule

// File: rtl/stat_finalize.sv
// Turns window totals into a mean and a variance (combinational).
// Mean = sum >>> (c+1); variance = (sumsq >> (c+1)) - mean^2, not below 0.
// Assumes: the mean fits in SAMPLE_W bits, which holds for any average.
module stat_finalize #(
    parameter int SAMPLE_W = 14,
    parameter int CYC_W    = 4,
    parameter int SUM_W    = 30,
    parameter int SQ_W     = 43,
    parameter int VAR_W    = 28
) (
    input  logic [CYC_W-1:0]           snap_cyc,
    input  logic signed [SUM_W-1:0]    snap_sum,
    input  logic [SQ_W-1:0]            snap_sq,
    output logic signed [SAMPLE_W-1:0] mean_o,
    output logic [VAR_W-1:0]           var_o
);
    logic [CYC_W:0]               sh;
    logic signed [2*SAMPLE_W-1:0] msq;
    logic [SQ_W-1:0]              ex2;
    logic signed [SQ_W:0]         diff;

    assign sh     = {1'b0, snap_cyc} + (CYC_W+1)'(1);
    assign mean_o = SAMPLE_W'(snap_sum >>> sh);
    assign msq    = mean_o * mean_o;
    assign ex2    = snap_sq >> sh;
    assign diff   = $signed({1'b0, ex2}) - (SQ_W+1)'(msq);
    assign var_o  = diff[SQ_W] ? '0 : VAR_W'(diff);
endmodule

// File: rtl/stat_result_bank.sv
// Per-channel result registers and the done pulse.
// Assumes: wr_en is already gated by enable; one channel is written per write.
module stat_result_bank #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 14,
    parameter int VAR_W    = 28,
    parameter int SEL_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_last,
    input  logic [SEL_W-1:0]           wr_ch,
    input  logic signed [SAMPLE_W-1:0] mean_in,
    input  logic [VAR_W-1:0]           var_in,
    output logic [NUM_CH*SAMPLE_W-1:0] mean_bus,
    output logic [NUM_CH*VAR_W-1:0]    var_bus,
    output logic                       done
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SAMPLE_W-1:0] mean_r;
        logic [VAR_W-1:0]    var_r;

        // Hold this channel's latest mean and variance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mean_r <= '0;
                var_r  <= '0;
            end else if (wr_en && wr_ch == SEL_W'(c)) begin
                mean_r <= mean_in;
                var_r  <= var_in;
            end
        end

        assign mean_bus[c*SAMPLE_W +: SAMPLE_W] = mean_r;
        assign var_bus[c*VAR_W +: VAR_W]        = var_r;
    end

    // One-cycle pulse when the final window of a measurement lands.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= wr_en && wr_last;
    end
endmodule

// File: rtl/adc_stat_monitor.sv
// Windowed ADC mean/variance monitor (top).
// Picks one channel's sample from the packed bus, accumulates it over a
// 2^(c+1) sample window and writes mean and variance per channel.
// Assumes: NUM_CH is a power of two of at least 2; configuration is
// set while disabled or accepted as an abort.
module adc_stat_monitor #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 14,
    parameter int CYC_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_enable,
    input  logic [CYC_W-1:0]             cfg_cycle,
    input  logic [$clog2(NUM_CH)-1:0]    cfg_chan,
    input  logic                         cfg_sweep,
    input  logic                         smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
    output logic [NUM_CH*SAMPLE_W-1:0]   res_mean,
    output logic [NUM_CH*2*SAMPLE_W-1:0] res_var,
    output logic                         stat_done
);
    localparam int SEL_W = $clog2(NUM_CH);
    localparam int VAR_W = 2 * SAMPLE_W;
    localparam int SUM_W = SAMPLE_W + (1 << CYC_W);
    localparam int SQ_W  = 2 * SAMPLE_W - 1 + (1 << CYC_W);
    localparam int CNT_W = (1 << CYC_W) + 1;

    logic [SAMPLE_W-1:0]        lane [NUM_CH];
    logic [SEL_W-1:0]           cur_ch;
    logic                       take, win_end, last_win, flush;
    logic                       snap_vld, snap_last;
    logic [SEL_W-1:0]           snap_ch;
    logic [CYC_W-1:0]           snap_cyc;
    logic signed [SUM_W-1:0]    snap_sum;
    logic [SQ_W-1:0]            snap_sq;
    logic signed [SAMPLE_W-1:0] fin_mean;
    logic [VAR_W-1:0]           fin_var;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign lane[c] = smp_data[c*SAMPLE_W +: SAMPLE_W];
    end

    stat_sequencer #(.NUM_CH(NUM_CH), .CYC_W(CYC_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .valid(smp_valid),
        .cfg_cycle(cfg_cycle), .cfg_chan(cfg_chan), .cfg_sweep(cfg_sweep),
        .cur_ch(cur_ch), .take(take), .win_end(win_end), .last_win(last_win), .flush(flush)
    );

    stat_accum #(.SAMPLE_W(SAMPLE_W), .CYC_W(CYC_W), .SEL_W(SEL_W), .SUM_W(SUM_W), .SQ_W(SQ_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .flush(flush), .take(take), .win_end(win_end),
        .last_win(last_win), .ch(cur_ch), .cycle(cfg_cycle), .sample($signed(lane[cur_ch])),
        .snap_vld(snap_vld), .snap_last(snap_last), .snap_ch(snap_ch), .snap_cyc(snap_cyc),
        .snap_sum(snap_sum), .snap_sq(snap_sq)
    );

    stat_finalize #(.SAMPLE_W(SAMPLE_W), .CYC_W(CYC_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .VAR_W(VAR_W)) u_fin (
        .snap_cyc(snap_cyc), .snap_sum(snap_sum), .snap_sq(snap_sq),
        .mean_o(fin_mean), .var_o(fin_var)
    );

    stat_result_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .VAR_W(VAR_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(snap_vld && cfg_enable), .wr_last(snap_last),
        .wr_ch(snap_ch), .mean_in(fin_mean), .var_in(fin_var),
        .mean_bus(res_mean), .var_bus(res_var), .done(stat_done)
    );
endmodule

// File: rtl/adc_stat_monitor_chk.sv
// Assertion checker for adc_stat_monitor, attached by bind.
// Assumes: it sees the top-level ports only.
module adc_stat_monitor_chk #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 14
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_enable,
    input logic                         smp_valid,
    input logic [NUM_CH*SAMPLE_W-1:0]   res_mean,
    input logic [NUM_CH*2*SAMPLE_W-1:0] res_var,
    input logic                         stat_done
);
    localparam int VAR_W = 2 * SAMPLE_W;

    p_done_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> $past(cfg_enable));

    p_results_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_enable) |-> ($stable(res_mean) && $stable(res_var)));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |=> !stat_done);

    p_done_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> $past(smp_valid, 2));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_var
        p_var_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            res_var[c*VAR_W +: VAR_W] <= (VAR_W'(1) << (2*SAMPLE_W - 2)));
    end
endmodule

bind adc_stat_monitor adc_stat_monitor_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .smp_valid(smp_valid),
    .res_mean(res_mean), .res_var(res_var), .stat_done(stat_done)
);

// File: tb/sim_adc_stat_monitor.sv
// Scoreboard bench: window tasks push expected results, a monitor compares.
module sim_adc_stat_monitor;
    localparam int NC = 4;
    localparam int SW = 14;
    localparam int VW = 28;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_enable = 1'b0;
    logic [3:0]       cfg_cycle = '0;
    logic [1:0]       cfg_chan = '0;
    logic             cfg_sweep = 1'b0;
    logic             smp_valid = 1'b0;
    logic [NC*SW-1:0] smp_data = '0;
    logic [NC*SW-1:0] res_mean;
    logic [NC*VW-1:0] res_var;
    logic             stat_done;

    typedef struct {
        int     cyc;
        int     ch;
        longint mean;
        longint var_v;
        bit     done;
        string  req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc_n = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    adc_stat_monitor u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cycle(cfg_cycle),
        .cfg_chan(cfg_chan), .cfg_sweep(cfg_sweep), .smp_valid(smp_valid),
        .smp_data(smp_data), .res_mean(res_mean), .res_var(res_var), .stat_done(stat_done)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint mean_of(int ch);
        return longint'($signed(res_mean[ch*SW +: SW]));
    endfunction

    function automatic longint var_of(int ch);
        return longint'(res_var[ch*VW +: VW]);
    endfunction

    function automatic int gen(int ch, int i, int base, int kind);
        case (kind)
            1:       return (i % 2 == 0) ? 8191 : -8192;
            2:       return base;
            3:       return (i == 0) ? -1 : 0;
            default: return ((i * 523 + ch * 2711 + base * 97) % 4001) - 2000;
        endcase
    endfunction

    // Monitor: compares results at the cycle each expected item is due.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].cyc == cyc_n) begin
                chk({q[0].req, " mean"}, mean_of(q[0].ch), q[0].mean);
                chk({q[0].req, " variance"}, var_of(q[0].ch), q[0].var_v);
                chk({q[0].req, " R11 done"}, longint'(stat_done), longint'(q[0].done));
                void'(q.pop_front());
            end else if (stat_done) begin
                chk("R9/R8 unexpected done", 1, 0);
            end
            if (q.size() > 0 && q[0].cyc < cyc_n) begin
                chk({q[0].req, " missed"}, cyc_n, q[0].cyc);
                void'(q.pop_front());
            end
        end
    end

    // Driver: one full window, measured channel ch, expectation queued.
    task automatic run_win(int ch, int k, int base, int kind, bit last, bit gaps, string req);
        longint s = 0;
        longint sq = 0;
        int n = 1 << (k + 1);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                smp_valid = 1'b0;
                smp_data[ch*SW +: SW] = 14'h1555;
                @(negedge clk);
            end
            for (int c = 0; c < NC; c++) begin
                int d = (c == ch) ? gen(c, i, base, kind) : gen(c, i, base + 7, 0);
                smp_data[c*SW +: SW] = d[SW-1:0];
                if (c == ch) begin
                    s += d;
                    sq += longint'(d) * d;
                end
            end
            smp_valid = 1'b1;
            if (i == n - 1) begin
                exp_t it;
                longint m = s >>> (k + 1);
                longint v = (sq >> (k + 1)) - m * m;
                if (v < 0) v = 0;
                it.cyc = cyc_n + 2; it.ch = ch; it.mean = m; it.var_v = v;
                it.done = last; it.req = req;
                q.push_back(it);
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic drive_raw(int count, int base);
        for (int i = 0; i < count; i++) begin
            for (int c = 0; c < NC; c++) begin
                int d = gen(c, i, base, 0);
                smp_data[c*SW +: SW] = d[SW-1:0];
            end
            smp_valid = 1'b1;
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic start(int cyc, int ch, bit sw);
        cfg_enable = 1'b0;
        cfg_cycle = 4'(cyc); cfg_chan = 2'(ch); cfg_sweep = sw;
        @(negedge clk);
        cfg_enable = 1'b1;
    endtask

    task automatic settle();
        smp_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        longint sm [NC];
        longint sv [NC];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int c = 0; c < NC; c++) begin
            chk("R1 mean after reset", mean_of(c), 0);
            chk("R1 variance after reset", var_of(c), 0);
        end
        chk("R1 done after reset", longint'(stat_done), 0);

        // R3 R4: smallest window, negative mean, variance clamps to zero
        start(0, 2, 1'b0);
        run_win(2, 0, 0, 3, 1'b1, 1'b0, "R4 clamp");
        settle();

        // R5 R10: channel 1, 16 samples with invalid gaps; others untouched
        for (int c = 0; c < NC; c++) begin sm[c] = mean_of(c); sv[c] = var_of(c); end
        start(3, 1, 1'b0);
        run_win(1, 3, 5, 0, 1'b1, 1'b1, "R10 gaps");
        settle();
        for (int c = 0; c < NC; c++) begin
            if (c != 1) begin
                chk("R5 other channel mean kept", mean_of(c), sm[c]);
                chk("R5 other channel variance kept", var_of(c), sv[c]);
            end
        end

        // R6 R7: sweep through all channels, then again from channel 0
        start(1, 0, 1'b1);
        run_win(0, 1, 10, 0, 1'b0, 1'b0, "R6 sweep ch0");
        run_win(1, 1, 11, 0, 1'b0, 1'b0, "R6 sweep ch1");
        run_win(2, 1, 12, 0, 1'b0, 1'b0, "R6 sweep ch2");
        run_win(3, 1, 13, 0, 1'b1, 1'b0, "R6 sweep ch3");
        run_win(0, 1, 14, 0, 1'b0, 1'b0, "R7 restart ch0");
        settle();

        // R3 R4: full-scale alternating samples
        start(2, 0, 1'b0);
        run_win(0, 2, 0, 1, 1'b1, 1'b0, "R3 full scale");
        settle();

        // R8: disabled, samples have no effect
        cfg_enable = 1'b0;
        for (int c = 0; c < NC; c++) begin sm[c] = mean_of(c); sv[c] = var_of(c); end
        drive_raw(20, 3);
        settle();
        chk("R8 mean frozen", mean_of(0), sm[0]);
        chk("R8 variance frozen", var_of(0), sv[0]);

        // R8: partial window, disable, re-enable; only new samples count
        start(2, 0, 1'b0);
        drive_raw(5, 99);
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_enable = 1'b1;
        run_win(0, 2, 31, 0, 1'b1, 1'b0, "R8 fresh window");
        settle();

        // R9: config change on the last sample of a window wins
        start(1, 3, 1'b0);
        run_win(3, 1, 40, 0, 1'b1, 1'b0, "R9 setup");
        settle();
        sm[3] = mean_of(3); sv[3] = var_of(3);
        drive_raw(3, 77);
        for (int c = 0; c < NC; c++) smp_data[c*SW +: SW] = 14'h0ABC;
        smp_valid = 1'b1;
        cfg_cycle = 4'd0;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 abort keeps mean", mean_of(3), sm[3]);
        chk("R9 abort keeps variance", var_of(3), sv[3]);
        run_win(3, 0, 41, 0, 1'b1, 1'b0, "R9 after abort");
        settle();

        // R9: abort mid-sweep restarts at channel 0
        start(0, 0, 1'b1);
        run_win(0, 0, 50, 0, 1'b0, 1'b0, "R9 sweep ch0");
        run_win(1, 0, 51, 0, 1'b0, 1'b0, "R9 sweep ch1");
        drive_raw(1, 52);
        cfg_cycle = 4'd1;
        @(negedge clk);
        run_win(0, 1, 53, 0, 1'b0, 1'b0, "R9 sweep restart ch0");
        settle();

        // R2: largest window, constant input
        start(15, 1, 1'b0);
        run_win(1, 15, -5, 2, 1'b1, 1'b0, "R2 max window");
        settle();
        cfg_enable = 1'b0;
        settle();
        chk("R2 queue drained", q.size(), 0);
        finish_run();
    end
endmodule